// File: doc/BRIEF.md
# DMA External Request Sampler

This block turns an active-low external transfer request into bus-cycle requests for one DMA channel. The pin is synchronized, then detected either on a falling edge or on a low level, as a mode input selects. A detection is followed by a fixed latency before the channel asks for the bus. Software-side logic loads a transfer count. The block counts down real transfers and stops requesting once the count reaches zero.

In burst operation the channel keeps requesting back to back until the count is used up. When burst is combined with single-address operation, the first cycle after a load is a dummy cycle. It is flagged on `dummy_o`, and the count does not drop for it. In cycle-steal operation every transfer needs its own detection. The sampling window closes at detection and opens again when the bus cycle produced by that detection starts, so the next detection overlaps the running transfer.

Top module: `dreq_sampler`

## Requirements
- R1: The request pin passes through a SYNC_STAGES-deep synchronizer (default 2) before detection. A low driven on the pin reaches the detector SYNC_STAGES clocks later.
- R2: With `level_mode_i`=0, detection fires only on a high-to-low transition of the synchronized pin. A pin held low does not trigger again.
- R3: With `level_mode_i`=1, a low synchronized pin triggers detection whenever the sampling window is open.
- R4: `cyc_req_o` rises LAT_STATES (default 3) clocks after the clock edge that registers a detection. From a pin drop to the request this is 6 clocks by default.
- R5: `cyc_req_o` stays high until a clock with `bus_start_i`=1.
- R6: With `burst_i`=1 and `single_addr_i`=1, the first requested cycle after a load has `dummy_o`=1. Starting that cycle leaves the count unchanged, so a load of N needs N+1 bus starts.
- R7: In burst mode, after a dummy or real cycle starts and the count is not exhausted, `cyc_req_o` stays high with no gap. Each real cycle start lowers the count by one.
- R8: `dummy_o` is never 1 when `single_addr_i`=0 or `burst_i`=0.
- R9: `sample_win_o` is 0 from detection until the bus cycle it produced starts. In cycle-steal mode it then reopens if the count is nonzero.
- R10: `cnt_zero_o` is 1 when the count is zero, including after the last real transfer and after a load of 0. No detection or request happens until a nonzero load.
- R11: `bus_start_i` while `cyc_req_o`=0 has no effect on the count or the outputs.
- R12: After reset, `cyc_req_o`=0, `dummy_o`=0, `cnt_zero_o`=1 and `sample_win_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | 1 | External request pin, active low, asynchronous |
| level_mode_i | input | 1 | 1: low-level detection, 0: falling-edge detection |
| burst_i | input | 1 | 1: burst, 0: cycle steal |
| single_addr_i | input | 1 | 1: single-address operation |
| load_i | input | 1 | Load count and re-arm the channel |
| load_cnt_i | input | CNT_W | Transfer count to load |
| bus_start_i | input | 1 | The requested bus cycle starts this clock |
| cyc_req_o | output | 1 | Bus cycle request |
| dummy_o | output | 1 | The requested cycle is a dummy cycle |
| cnt_zero_o | output | 1 | Transfer count is zero |
| sample_win_o | output | 1 | Pin sampling window open |

## Verification
The assertions assume that the mode inputs change only while the channel is idle or together with a load. The stimulus changes them only in the clock of `load_i`. They also assume that `bus_start_i` is a single-clock strobe that answers a pending request. The bench raises it for exactly one clock, either after seeing `cyc_req_o` or on purpose while no request is pending, to exercise R11. Pin changes are driven away from the clock edge, so the synchronizer sees clean levels, and the model follows the same sampling point.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef struct packed {
    logic level;
    logic burst;
    logic single;
  } dreq_mode_t;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  output logic pin_low_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= pin_ni;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], pin_ni};
      end
    end
  endgenerate

  assign pin_low_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/dreq_detect.sv
module dreq_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_low_i,
  input  logic level_i,
  input  logic window_i,
  output logic hit_o
);
  logic prev_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_low_q <= 1'b0;
    else         prev_low_q <= pin_low_i;
  end

  assign hit_o = window_i & pin_low_i & (level_i | ~prev_low_q);

  // R2
  edge_single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && hit_o) |=> !hit_o);
endmodule

// File: rtl/dreq_count.sv
module dreq_count #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o,
  output logic         last_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - ONE;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == ONE);

  // R10
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);
endmodule

// File: rtl/dreq_seq.sv
module dreq_seq #(
  parameter int W   = 8,
  parameter int LAT = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         hit_i,
  input  logic         bus_start_i,
  input  logic         burst_i,
  input  logic         single_i,
  input  logic         zero_i,
  input  logic         last_i,
  input  logic [W-1:0] cnt_i,
  output logic         window_o,
  output logic         dec_o,
  output logic         cyc_req_o,
  output logic         dummy_o
);
  localparam int WAIT_W = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(LAT - 1);
  localparam logic [W-1:0] ONE = W'(1);

  logic              open_q, first_q, pend_q, req_q, dummy_q;
  logic [WAIT_W-1:0] wait_q;
  logic              start_ok;

  assign start_ok = req_q & bus_start_i;
  assign dec_o    = start_ok & ~dummy_q & ~load_i;
  assign window_o = open_q & ~zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q  <= 1'b0;
      first_q <= 1'b0;
      pend_q  <= 1'b0;
      req_q   <= 1'b0;
      dummy_q <= 1'b0;
      wait_q  <= '0;
    end else if (load_i) begin
      open_q  <= 1'b1;
      first_q <= 1'b1;
      pend_q  <= 1'b0;
      req_q   <= 1'b0;
      dummy_q <= 1'b0;
      wait_q  <= '0;
    end else begin
      if (start_ok) begin
        if (dummy_q) begin
          dummy_q <= 1'b0;               // real data follows back to back
        end else if (last_i) begin
          req_q <= 1'b0;
        end else if (!burst_i) begin
          req_q  <= 1'b0;
          open_q <= 1'b1;                // re-sample during this cycle
        end
      end else if (pend_q) begin
        if (wait_q == '0) begin
          req_q  <= 1'b1;
          pend_q <= 1'b0;
        end else begin
          wait_q <= wait_q - 1'b1;
        end
      end
      if (hit_i) begin
        open_q  <= 1'b0;
        pend_q  <= 1'b1;
        wait_q  <= WAIT_INIT;
        dummy_q <= burst_i & single_i & first_q;
        first_q <= 1'b0;
      end
    end
  end

  assign cyc_req_o = req_q;
  assign dummy_o   = req_q & dummy_q;

  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !bus_start_i && !load_i) |=> req_q);
  // R6
  dummy_no_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok && dummy_q && !load_i) |=> $stable(cnt_i));
  // R7
  real_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_o) |=> (cnt_i == $past(cnt_i) - ONE));
  // R7
  burst_back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok && burst_i && !last_i && !load_i) |=> req_q);
  // R8
  dummy_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_o |-> (burst_i && single_i));
  // R9
  busy_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q || pend_q) |-> !window_o);
  // R10
  zero_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |-> (!req_q && !pend_q));
  // R11
  idle_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_start_i && !req_q && !load_i) |=> $stable(cnt_i));
endmodule

// File: rtl/dreq_sampler.sv
module dreq_sampler #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LAT_STATES  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_ni,
  input  logic             level_mode_i,
  input  logic             burst_i,
  input  logic             single_addr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             bus_start_i,
  output logic             cyc_req_o,
  output logic             dummy_o,
  output logic             cnt_zero_o,
  output logic             sample_win_o
);
  dreq_pkg::dreq_mode_t mode;
  logic             pin_low, hit, window, dec, zero, last;
  logic [CNT_W-1:0] cnt;

  assign mode = '{level: level_mode_i, burst: burst_i, single: single_addr_i};

  dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_ni(req_ni), .pin_low_o(pin_low)
  );

  dreq_detect u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_low_i(pin_low),
    .level_i(mode.level), .window_i(window), .hit_o(hit)
  );

  dreq_count #(.W(CNT_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .load_val_i(load_cnt_i),
    .dec_i(dec), .cnt_o(cnt), .zero_o(zero), .last_o(last)
  );

  dreq_seq #(.W(CNT_W), .LAT(LAT_STATES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .hit_i(hit),
    .bus_start_i(bus_start_i), .burst_i(mode.burst), .single_i(mode.single),
    .zero_i(zero), .last_i(last), .cnt_i(cnt), .window_o(window),
    .dec_o(dec), .cyc_req_o(cyc_req_o), .dummy_o(dummy_o)
  );

  assign cnt_zero_o   = zero;
  assign sample_win_o = window;
endmodule

// File: tb/dreq_sampler_test.sv
module dreq_sampler_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int SYNC  = 2;
  localparam int LAT   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_n = 1'b1, lvl = 1'b0, burst = 1'b0, single = 1'b0;
  logic load = 1'b0, bus_start = 1'b0;
  logic [CNT_W-1:0] load_val = '0;
  logic cyc_req, dummy, cnt_zero, win;

  int checks = 0, errors = 0;
  string cur_req = "R12";
  bit dummy_seen = 0;

  dreq_sampler #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC), .LAT_STATES(LAT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_ni(req_n), .level_mode_i(lvl),
    .burst_i(burst), .single_addr_i(single), .load_i(load),
    .load_cnt_i(load_val), .bus_start_i(bus_start), .cyc_req_o(cyc_req),
    .dummy_o(dummy), .cnt_zero_o(cnt_zero), .sample_win_o(win)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_cnt, m_wait;
  bit m_open, m_first, m_req, m_dummy, m_prev;
  bit hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist.delete();
      for (int i = 0; i < SYNC; i++) hist.push_back(1'b1);
      m_cnt = 0; m_wait = -1; m_open = 0; m_first = 0;
      m_req = 0; m_dummy = 0; m_prev = 0;
    end else begin
      bit low, det;
      low = (hist[0] == 1'b0);
      det = m_open && (m_cnt != 0) && low && (lvl || !m_prev);
      if (load) begin
        m_cnt = int'(load_val); m_open = 1; m_first = 1;
        m_wait = -1; m_req = 0; m_dummy = 0;
      end else begin
        if (m_req && bus_start) begin
          if (m_dummy) m_dummy = 0;
          else begin
            m_cnt--;
            if (m_cnt == 0) m_req = 0;
            else if (!burst) begin m_req = 0; m_open = 1; end
          end
        end else if (m_wait > 0) m_wait--;
        else if (m_wait == 0) begin m_req = 1; m_wait = -1; end
        if (det) begin
          m_open = 0; m_wait = LAT - 1;
          m_dummy = burst && single && m_first; m_first = 0;
        end
      end
      m_prev = low;
      hist.push_back(req_n);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_d;
      exp_d = m_req && m_dummy;
      chk(cyc_req == m_req, cur_req, "cyc_req_o", cyc_req, m_req);
      chk(dummy == exp_d, cur_req, "dummy_o", dummy, exp_d);
      chk(cnt_zero == (m_cnt == 0), cur_req, "cnt_zero_o", cnt_zero, m_cnt == 0);
      chk(win == (m_open && m_cnt != 0), cur_req, "sample_win_o", win,
          m_open && m_cnt != 0);
      if (dummy) dummy_seen = 1;
    end
  end

  task automatic do_load(input int n, input bit l, input bit b, input bit s);
    @(negedge clk);
    lvl = l; burst = b; single = s; load = 1'b1; load_val = CNT_W'(n);
    @(negedge clk);
    load = 1'b0;
    dummy_seen = 0;
  endtask

  task automatic serve(input int delay, output bit ok);
    int t = 0;
    while (!cyc_req && t < 60) begin @(negedge clk); t++; end
    ok = cyc_req;
    if (ok) begin
      repeat (delay) @(negedge clk);
      bus_start = 1'b1;
      @(negedge clk);
      bus_start = 1'b0;
    end
  endtask

  task automatic drain(input int delay, output int grants);
    bit ok;
    grants = 0;
    while (!cnt_zero && grants < 20) begin
      serve(delay, ok);
      if (!ok) break;
      grants++;
    end
  endtask

  task automatic quiet(input int n, input string req);
    bit any = 0;
    repeat (n) begin @(negedge clk); if (cyc_req) any = 1; end
    chk(!any, req, "no request", any, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat, g;
    bit ok;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!cyc_req && !dummy && cnt_zero && !win, "R12", "reset outputs",
        {cyc_req, dummy, cnt_zero, win}, 4'b0010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R4 latency, R2 edge mode no retrigger, cycle steal dual
    cur_req = "R4";
    do_load(3, 0, 0, 0);
    req_n = 1'b0; lat = 0;
    while (!cyc_req && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == SYNC + LAT + 1, "R1", "pin-to-request clocks", lat, SYNC + LAT + 1);
    chk(lat == SYNC + LAT + 1, "R4", "detect latency", lat, SYNC + LAT + 1);
    cur_req = "R2";
    serve(0, ok);
    chk(win == 1'b1, "R9", "window reopened after cycle-steal start", win, 1);
    quiet(20, "R2");
    req_n = 1'b1; repeat (3) @(negedge clk);
    req_n = 1'b0;
    serve(0, ok);
    chk(ok, "R2", "new falling edge served", ok, 1);
    req_n = 1'b1; repeat (4) @(negedge clk);

    // R3 R5 R9 R10 level mode with delayed grants
    cur_req = "R3";
    do_load(4, 1, 0, 0);
    req_n = 1'b0;
    drain(5, g);
    chk(g == 4, "R3", "level-mode transfers", g, 4);
    chk(cnt_zero == 1'b1, "R10", "count zero after last", cnt_zero, 1);
    cur_req = "R10";
    quiet(12, "R10");
    req_n = 1'b1; repeat (3) @(negedge clk);

    // R6 R7 burst single address: dummy first, count untouched
    cur_req = "R6";
    do_load(3, 0, 1, 1);
    req_n = 1'b0; repeat (2) @(negedge clk); req_n = 1'b1;
    while (!cyc_req) @(negedge clk);
    chk(dummy == 1'b1, "R6", "first burst cycle is dummy", dummy, 1);
    cur_req = "R7";
    drain(0, g);
    chk(g == 4, "R6", "bus starts incl. dummy", g, 4);
    chk(cnt_zero == 1'b1, "R7", "count exhausted", cnt_zero, 1);
    repeat (3) @(negedge clk);

    // R8 burst dual address: no dummy
    cur_req = "R8";
    do_load(3, 0, 1, 0);
    req_n = 1'b0; repeat (2) @(negedge clk); req_n = 1'b1;
    drain(0, g);
    chk(g == 3 && !dummy_seen, "R8", "burst dual starts, dummy seen",
        g * 10 + dummy_seen, 30);

    // R8 cycle steal single address: no dummy
    do_load(2, 1, 0, 1);
    req_n = 1'b0;
    drain(1, g);
    req_n = 1'b1;
    chk(g == 2 && !dummy_seen, "R8", "cycle-steal single starts, dummy seen",
        g * 10 + dummy_seen, 20);
    repeat (3) @(negedge clk);

    // R11 idle bus starts ignored
    cur_req = "R11";
    do_load(2, 0, 0, 0);
    repeat (3) begin
      @(negedge clk); bus_start = 1'b1;
      @(negedge clk); bus_start = 1'b0;
    end
    chk(!cnt_zero && win, "R11", "state after idle starts", {cnt_zero, win}, 2'b01);
    req_n = 1'b0; repeat (2) @(negedge clk); req_n = 1'b1;
    serve(0, ok);
    repeat (2) @(negedge clk);
    req_n = 1'b0; repeat (2) @(negedge clk); req_n = 1'b1;
    serve(0, ok);
    chk(cnt_zero == 1'b1, "R11", "two transfers used full count", cnt_zero, 1);

    // R10 load of zero
    cur_req = "R10";
    do_load(0, 1, 0, 0);
    req_n = 1'b0;
    quiet(10, "R10");
    chk(cnt_zero && !win, "R10", "zero load idle", {cnt_zero, win}, 2'b10);
    req_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule